// File: doc/BRIEF.md
# Indirect Register File Addressing Unit

This unit sits between an instruction decoder and a 512-entry, 8-bit data register file and turns every file-register access into a physical address, a read value and a write request. A direct access builds its address from a two-bit bank select and the 7-bit address field of the instruction. When the address field holds offset 0, the unit does not access a physical register. It takes the address from an 8-bit pointer instead, and a one-bit bank flag from the status register becomes the top bit. Software can step the pointer with ordinary arithmetic, so repeated accesses to offset 0 move through consecutive file locations.

When the pointer itself selects offset 0 of any bank, it refers back to the pointer window, and that location has no storage. Reads from it return zero and writes to it are dropped. The write port to the file is registered, so the store lands one cycle after the strobe. A read in that cycle to the same location receives the pending data through a forwarding path. The read address and read data stay combinational.

Top module: `indaddr_unit`

## Requirements
- R1: When the address field is nonzero, the resolved file address is the 2-bit direct bank select (bits 8:7) concatenated with the 7-bit field (bits 6:0).
- R2: When the address field is zero, the resolved file address is the status bank flag (bit 8) concatenated with the 8-bit pointer value (bits 7:0).
- R3: With the read strobe high on a non-self-referencing access, the read data equals the file's data at the resolved address.
- R4: When the address field is zero and the pointer's low 7 bits are zero (addresses 0x000, 0x080, 0x100, 0x180), the read data is 0x00.
- R5: A write strobe under the same self-referencing condition as R4 produces no file write enable in the following cycle.
- R6: A write strobe on any other access raises the file write enable in exactly the next cycle, for one cycle, with the resolved address and the strobe-cycle write data on the write port.
- R7: A read in the cycle when a write to the same resolved address is on the write port returns the pending write data instead of the file's data.
- R8: While reset is asserted, and for two clock edges after it is released, the file write enable is low.
- R9: With the read strobe low, the read data is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_field | input | 7 | Address field of the instruction |
| dbank | input | 2 | Bank select for direct accesses |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| wr_data | input | 8 | Data to store |
| ptr_val | input | 8 | Current value of the file-select pointer |
| ptr_bank | input | 1 | Status-register bank flag for pointer accesses |
| file_rdata | input | 8 | Data the file returns at file_raddr |
| file_raddr | output | 9 | Resolved read address to the file |
| rd_data | output | 8 | Read result to the datapath |
| file_we | output | 1 | Registered write enable to the file |
| file_waddr | output | 9 | Registered write address |
| file_wdata | output | 8 | Registered write data |

## Verification
On every cycle, the assertions check the address formation for both access kinds and the zero read for self-referencing and unstrobed accesses. They also check that a strobe becomes a single-cycle enable, or no enable at all for a self-referencing target, and that the enable stays low during reset. Only the bench's scenarios can show that the data stored actually reaches the right location. For this, the bench keeps its own model of the file, and later reads must match that model after pointer walks across bank and 0x80 boundaries, after dropped writes, and after a read issued right behind a write to the same address.

// File: rtl/ifa_pkg.sv
package ifa_pkg;
  localparam int unsigned FIELD_W_D = 7;
  localparam int unsigned PTR_W_D   = 8;
  localparam int unsigned DATA_W_D  = 8;

  typedef enum logic [1:0] {
    ACC_DIRECT = 2'd0,
    ACC_PTR    = 2'd1,
    ACC_SELF   = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/ifa_resolve.sv
module ifa_resolve
  import ifa_pkg::*;
#(
  parameter int unsigned FIELD_W = FIELD_W_D,
  parameter int unsigned PTR_W   = PTR_W_D,
  parameter int unsigned WIN_OFS = 0,
  localparam int unsigned ADDR_W  = PTR_W + 1,
  localparam int unsigned DBANK_W = ADDR_W - FIELD_W
) (
  input  logic [FIELD_W-1:0] addr_field,
  input  logic [DBANK_W-1:0] dbank,
  input  logic [PTR_W-1:0]   ptr_val,
  input  logic               ptr_bank,
  output logic [ADDR_W-1:0]  res_addr,
  output acc_kind_e          kind
);
  localparam logic [FIELD_W-1:0] WIN = FIELD_W'(WIN_OFS);

  logic via_ptr;
  logic ptr_hits_win;

  always_comb begin
    via_ptr      = (addr_field == WIN);
    ptr_hits_win = (ptr_val[FIELD_W-1:0] == WIN);
    if (via_ptr) begin
      res_addr = {ptr_bank, ptr_val};
      kind     = ptr_hits_win ? ACC_SELF : ACC_PTR;
    end else begin
      res_addr = {dbank, addr_field};
      kind     = ACC_DIRECT;
    end
  end
endmodule

// File: rtl/ifa_wport.sv
module ifa_wport #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata
);
  logic              we_d;
  logic              ld_en;
  logic [ADDR_W-1:0] waddr_d;
  logic [DATA_W-1:0] wdata_d;

  always_comb begin
    we_d    = wr_req;
    ld_en   = wr_req;
    waddr_d = ld_en ? wr_addr : waddr;
    wdata_d = ld_en ? wr_data : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we    <= 1'b0;
      waddr <= '0;
      wdata <= '0;
    end else begin
      we    <= we_d;
      waddr <= waddr_d;
      wdata <= wdata_d;
    end
  end
endmodule

// File: rtl/ifa_rdsel.sv
module ifa_rdsel
  import ifa_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = 8
) (
  input  acc_kind_e         kind,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] res_addr,
  input  logic [DATA_W-1:0] file_rdata,
  input  logic              pend_we,
  input  logic [ADDR_W-1:0] pend_addr,
  input  logic [DATA_W-1:0] pend_data,
  output logic [DATA_W-1:0] rd_data
);
  logic fwd;

  always_comb begin
    fwd = pend_we && (pend_addr == res_addr);
    if (!rd_stb || kind == ACC_SELF) rd_data = '0;
    else if (fwd)                    rd_data = pend_data;
    else                             rd_data = file_rdata;
  end
endmodule

// File: rtl/indaddr_unit.sv
module indaddr_unit
  import ifa_pkg::*;
#(
  parameter int unsigned FIELD_W = FIELD_W_D,
  parameter int unsigned PTR_W   = PTR_W_D,
  parameter int unsigned DATA_W  = DATA_W_D,
  parameter int unsigned WIN_OFS = 0,
  localparam int unsigned ADDR_W  = PTR_W + 1,
  localparam int unsigned DBANK_W = ADDR_W - FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] addr_field,
  input  logic [DBANK_W-1:0] dbank,
  input  logic               rd_stb,
  input  logic               wr_stb,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [PTR_W-1:0]   ptr_val,
  input  logic               ptr_bank,
  input  logic [DATA_W-1:0]  file_rdata,
  output logic [ADDR_W-1:0]  file_raddr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               file_we,
  output logic [ADDR_W-1:0]  file_waddr,
  output logic [DATA_W-1:0]  file_wdata
);
  logic [1:0]        rst_sync;
  logic              rst_q;
  logic [ADDR_W-1:0] res_addr;
  acc_kind_e         kind;
  logic              wr_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  ifa_resolve #(.FIELD_W(FIELD_W), .PTR_W(PTR_W), .WIN_OFS(WIN_OFS)) u_res (
    .addr_field (addr_field),
    .dbank      (dbank),
    .ptr_val    (ptr_val),
    .ptr_bank   (ptr_bank),
    .res_addr   (res_addr),
    .kind       (kind)
  );

  assign wr_req     = wr_stb && (kind != ACC_SELF);
  assign file_raddr = res_addr;

  ifa_wport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wp (
    .clk     (clk),
    .rst_n   (rst_q),
    .wr_req  (wr_req),
    .wr_addr (res_addr),
    .wr_data (wr_data),
    .we      (file_we),
    .waddr   (file_waddr),
    .wdata   (file_wdata)
  );

  ifa_rdsel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .kind       (kind),
    .rd_stb     (rd_stb),
    .res_addr   (res_addr),
    .file_rdata (file_rdata),
    .pend_we    (file_we),
    .pend_addr  (file_waddr),
    .pend_data  (file_wdata),
    .rd_data    (rd_data)
  );
endmodule

// File: rtl/ifa_chk.sv
module ifa_chk #(
  parameter int unsigned FIELD_W = 7,
  parameter int unsigned PTR_W   = 8,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned ADDR_W  = PTR_W + 1,
  localparam int unsigned DBANK_W = ADDR_W - FIELD_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rst_q,
  input logic [FIELD_W-1:0] addr_field,
  input logic [DBANK_W-1:0] dbank,
  input logic               rd_stb,
  input logic               wr_stb,
  input logic [DATA_W-1:0]  wr_data,
  input logic [PTR_W-1:0]   ptr_val,
  input logic               ptr_bank,
  input logic [ADDR_W-1:0]  file_raddr,
  input logic [DATA_W-1:0]  rd_data,
  input logic               file_we,
  input logic [ADDR_W-1:0]  file_waddr,
  input logic [DATA_W-1:0]  file_wdata
);
  logic at_win;
  logic self_ref;
  assign at_win   = (addr_field == '0);
  assign self_ref = at_win && (ptr_val[FIELD_W-1:0] == '0);

  a_r1_direct_addr: assert property (@(posedge clk) disable iff (!rst_n)
    !at_win |-> file_raddr == {dbank, addr_field});
  a_r2_ptr_addr: assert property (@(posedge clk) disable iff (!rst_n)
    at_win |-> file_raddr == {ptr_bank, ptr_val});
  a_r4_self_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    self_ref |-> rd_data == '0);
  a_r9_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |-> rd_data == '0);
  a_r5_self_write_dropped: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_stb && self_ref) |=> !file_we);
  a_r6_write_issued: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_stb && !self_ref) |=> (file_we && file_wdata == $past(wr_data)
                               && file_waddr == $past(file_raddr)));
  a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_q)
    !wr_stb |=> !file_we);
  a_r8_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_q |-> !file_we);
endmodule

bind indaddr_unit ifa_chk #(.FIELD_W(FIELD_W), .PTR_W(PTR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_q      (rst_q),
  .addr_field (addr_field),
  .dbank      (dbank),
  .rd_stb     (rd_stb),
  .wr_stb     (wr_stb),
  .wr_data    (wr_data),
  .ptr_val    (ptr_val),
  .ptr_bank   (ptr_bank),
  .file_raddr (file_raddr),
  .rd_data    (rd_data),
  .file_we    (file_we),
  .file_waddr (file_waddr),
  .file_wdata (file_wdata)
);

// File: tb/tb_indaddr_unit.sv
`timescale 1ns/1ps
module tb_indaddr_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] addr_field;
  logic [1:0] dbank;
  logic       rd_stb, wr_stb;
  logic [7:0] wr_data, ptr_val;
  logic       ptr_bank;
  logic [7:0] file_rdata;
  logic [8:0] file_raddr, file_waddr;
  logic [7:0] rd_data, file_wdata;
  logic       file_we;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] filemem [512];
  logic [7:0] refmem  [512];
  bit         pend_v;
  int         pend_a, pend_d;

  always #5 clk = ~clk;

  indaddr_unit dut (
    .clk(clk), .rst_n(rst_n), .addr_field(addr_field), .dbank(dbank),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data), .ptr_val(ptr_val),
    .ptr_bank(ptr_bank), .file_rdata(file_rdata), .file_raddr(file_raddr),
    .rd_data(rd_data), .file_we(file_we), .file_waddr(file_waddr),
    .file_wdata(file_wdata)
  );

  assign file_rdata = filemem[file_raddr];
  always @(posedge clk) if (file_we) filemem[file_waddr] <= file_wdata;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One access: drive after the falling edge, compare, then advance the model at the rising edge.
  task automatic step(input int fld, input int db, input bit rd, input bit wr,
                      input int wd, input int pv, input bit pb);
    int  ea, er;
    bit  ind, slf;
    @(negedge clk);
    addr_field = 7'(fld); dbank = 2'(db); rd_stb = rd; wr_stb = wr;
    wr_data = 8'(wd); ptr_val = 8'(pv); ptr_bank = pb;
    #1;
    ind = (fld == 0);
    slf = ind && ((pv % 128) == 0);
    ea  = ind ? (pb * 256 + pv) : (db * 128 + fld);
    chk(ind ? "R2 address" : "R1 address", int'(file_raddr), ea);
    if (!rd) begin
      chk("R9 idle read", int'(rd_data), 0);
    end else if (slf) begin
      chk("R4 self read", int'(rd_data), 0);
    end else if (pend_v && pend_a == ea) begin
      chk("R7 forwarded read", int'(rd_data), pend_d);
    end else begin
      er = int'(refmem[ea]);
      chk("R3 read data", int'(rd_data), er);
    end
    chk(pend_v ? "R6 write enable" : "R5 write enable low", int'(file_we), int'(pend_v));
    if (pend_v) begin
      chk("R6 write address", int'(file_waddr), pend_a);
      chk("R6 write data", int'(file_wdata), pend_d);
    end
    @(posedge clk);
    if (pend_v) refmem[pend_a] = 8'(pend_d);
    pend_v = wr && !slf;
    pend_a = ea;
    pend_d = wd % 256;
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin
      filemem[i] = 8'(i) ^ 8'h5A;
      refmem[i]  = 8'(i) ^ 8'h5A;
    end
    pend_v = 0; pend_a = 0; pend_d = 0;
    rst_n = 1'b0;
    addr_field = '0; dbank = '0; rd_stb = 0; wr_stb = 0;
    wr_data = '0; ptr_val = '0; ptr_bank = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 enable in reset", int'(file_we), 0);
    rst_n = 1'b1;
    // R8: strobes during the two-edge release window must not reach the file
    @(negedge clk); wr_stb = 1; addr_field = 7'h21; wr_data = 8'hEE;
    @(negedge clk); chk("R8 enable during release", int'(file_we), 0);
    wr_stb = 0;
    @(negedge clk); chk("R8 enable after release", int'(file_we), 0);
    repeat (2) step(5, 0, 0, 0, 0, 0, 0);

    // R1 / R3: direct reads across banks
    step(7'h21, 0, 1, 0, 0, 0, 0);
    step(7'h7F, 3, 1, 0, 0, 0, 0);
    step(7'h04, 2, 1, 0, 0, 0, 0);
    // R6 / R7: write followed immediately by a read of the same place
    step(7'h30, 1, 0, 1, 8'hA7, 0, 0);
    step(7'h30, 1, 1, 0, 0, 0, 0);
    step(7'h30, 1, 1, 0, 0, 0, 0);
    // read-modify-write in one cycle
    step(7'h31, 1, 1, 1, 8'h3C, 0, 0);
    step(7'h31, 1, 1, 0, 0, 0, 0);
    // R2: pointer accesses in both banks
    step(0, 3, 1, 0, 0, 8'h35, 1);
    step(0, 0, 0, 1, 8'h91, 8'h35, 1);
    step(0, 0, 1, 0, 0, 8'h35, 1);
    step(0, 0, 1, 0, 0, 8'hFF, 0);
    // R4 / R5: pointer at the window in every bank
    step(0, 0, 1, 1, 8'h11, 8'h00, 0);
    step(0, 0, 1, 1, 8'h22, 8'h80, 0);
    step(0, 0, 1, 1, 8'h33, 8'h00, 1);
    step(0, 0, 1, 1, 8'h44, 8'h80, 1);
    step(7'h01, 0, 1, 0, 0, 0, 0);
    // pointer walk across the 0x80 boundary (window skipped by R4/R5)
    for (int p = 8'h7C; p <= 8'h84; p++) step(0, 0, 0, 1, p + 8'h10, p, 1);
    for (int p = 8'h7C; p <= 8'h84; p++) step(0, 0, 1, 0, 0, p, 1);
    // back-to-back writes to different places, then reads
    for (int k = 1; k < 6; k++) step(7'h40 + k, k % 4, 0, 1, 8'hC0 + k, 0, 0);
    for (int k = 1; k < 6; k++) step(7'h40 + k, k % 4, 1, 0, 0, 0, 0);
    // R9: read strobe low hides file data
    step(7'h41, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 8'h35, 1);
    repeat (2) step(5, 0, 0, 0, 0, 0, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule